// File: doc/BRIEF.md
# Dithered Fractional DAC Code Generator

This block drives a 14-bit DAC that tunes a 25 MHz voltage-controlled oscillator and gives that DAC a finer average resolution than its 14 bits. A processor writes a setpoint in one access: an integer code and a 16-bit fraction. Once per update period, 40 cycles of the 25 MHz clock (625 kHz), the fraction is added into a 16-bit accumulator. The carry out of that sum is added to the integer code, and the result is sent to the DAC with a one-clock load strobe.

Because the carry is set on a share of updates equal to fraction/65536, the time-averaged code is integer + fraction/65536. That is 30 bits of averaged resolution, well past the 18 bits asked for. When the integer code is at full scale, the result stays at full scale and never wraps to zero. A setpoint write lands in a single register pair, and the pair is only sampled at an update, so a half-written setpoint is never used.

Top module: `dac_dither_gen`

## Requirements
- R1: After reset, `dac_code` is 0 and `dac_load` is 0. The setpoint and the fraction accumulator are cleared, so the first update adds the written fraction to an accumulator of 0.
- R2: `dac_load` is high for exactly one clock. Successive rising edges of `dac_load` are exactly TICK_DIV (40) clocks apart.
- R3: With a fraction of 0, every update drives `dac_code` equal to the written integer code.
- R4: At each update the accumulator becomes (acc + frac) mod 65536. The carry is 1 when acc + frac is at least 65536. The update drives `dac_code` = integer + carry.
- R5: When the integer code is 16383 (all ones) and the carry is 1, `dac_code` stays at 16383 and does not wrap.
- R6: `wr_en` loads the integer and the fraction together in one clock. The new pair first appears in `dac_code` at the next update. Between updates, `dac_code` does not change, even when a write occurs.
- R7: From reset, with a fixed fraction F, the number of carrying updates among the first N updates is floor(N*F/65536). Over 65536 updates this is exactly F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock (25 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Setpoint write strobe |
| wr_int | input | 14 | Integer DAC code to write |
| wr_frac | input | 16 | Fraction to write, in units of 1/65536 code |
| dac_code | output | 14 | Code presented to the DAC |
| dac_load | output | 1 | One-clock strobe marking a new `dac_code` |

## Verification
Inside the block, an update fires on the clock edge where the period counter reaches its last count. `dac_code` and `dac_load` are both registered on that edge, so a new code and its strobe appear together one clock after the update edge. A write is captured on the first edge after `wr_en` is driven, and it has no visible effect until the next `dac_load`. The bench drives inputs and samples outputs on the falling edge. It waits for `dac_load` to be high before comparing each code against its own accumulator model. For the "no effect between updates" case, it samples `dac_code` on the falling edge right after a write.

// File: rtl/dac_dither_pkg.sv
package dac_dither_pkg;
  localparam int unsigned DEF_CODE_W   = 14;
  localparam int unsigned DEF_FRAC_W   = 16;
  localparam int unsigned DEF_TICK_DIV = 40;
endpackage

// File: rtl/dd_tick_gen.sv
module dd_tick_gen #(
  parameter int unsigned TICK_DIV = dac_dither_pkg::DEF_TICK_DIV
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW   = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/dd_setpoint_reg.sv
module dd_setpoint_reg #(
  parameter int unsigned CODE_W = dac_dither_pkg::DEF_CODE_W,
  parameter int unsigned FRAC_W = dac_dither_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_int,
  input  logic [FRAC_W-1:0] wr_frac,
  output logic [CODE_W-1:0] int_q,
  output logic [FRAC_W-1:0] frac_q
);
  // Both halves live in one register pair written in a single clock.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q  <= '0;
      frac_q <= '0;
    end else if (wr_en) begin
      int_q  <= wr_int;
      frac_q <= wr_frac;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(int_q) && $stable(frac_q)));
endmodule

// File: rtl/dd_frac_accum.sv
module dd_frac_accum #(
  parameter int unsigned FRAC_W = dac_dither_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_d;

  // Returns {carry, wrapped sum}.
  function automatic logic [FRAC_W:0] frac_step(input logic [FRAC_W-1:0] a,
                                                input logic [FRAC_W-1:0] f);
    return {1'b0, a} + {1'b0, f};
  endfunction

  assign {carry, acc_d} = frac_step(acc_q, frac);

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (tick) acc_q <= acc_d;
  end

  p_acc_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc_q));
endmodule

// File: rtl/dd_code_out.sv
module dd_code_out #(
  parameter int unsigned CODE_W = dac_dither_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              carry,
  input  logic [CODE_W-1:0] int_in,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_load
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  // Adds the carry but holds at full scale.
  function automatic logic [CODE_W-1:0] sat_inc(input logic [CODE_W-1:0] base,
                                                input logic inc);
    if (inc && (base != CODE_MAX)) return base + 1'b1;
    return base;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_code <= '0;
      dac_load <= 1'b0;
    end else begin
      dac_load <= tick;
      if (tick) dac_code <= sat_inc(int_in, carry);
    end
  end

  p_load_follows_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> dac_load);
  p_load_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |=> !dac_load);
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (dac_code >= $past(int_in)));
  p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dac_code));
endmodule

// File: rtl/dac_dither_gen.sv
module dac_dither_gen #(
  parameter int unsigned CODE_W   = dac_dither_pkg::DEF_CODE_W,
  parameter int unsigned FRAC_W   = dac_dither_pkg::DEF_FRAC_W,
  parameter int unsigned TICK_DIV = dac_dither_pkg::DEF_TICK_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_int,
  input  logic [FRAC_W-1:0] wr_frac,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_load
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  // Named internal events for the checks.
  logic              upd_tick;
  logic              upd_carry;
  logic [CODE_W-1:0] sp_int;
  logic [FRAC_W-1:0] sp_frac;

  dd_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(upd_tick)
  );

  dd_setpoint_reg #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_sp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_int(wr_int),
    .wr_frac(wr_frac), .int_q(sp_int), .frac_q(sp_frac)
  );

  dd_frac_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .tick(upd_tick), .frac(sp_frac),
    .carry(upd_carry)
  );

  dd_code_out #(.CODE_W(CODE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .tick(upd_tick), .carry(upd_carry),
    .int_in(sp_int), .dac_code(dac_code), .dac_load(dac_load)
  );

  p_carry_adds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && upd_carry && (sp_int != CODE_MAX)) |=>
      (dac_code == $past(sp_int) + 1'b1));
  p_nocarry_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && !upd_carry) |=> (dac_code == $past(sp_int)));
  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && (sp_int == CODE_MAX)) |=> (dac_code == CODE_MAX));
endmodule

// File: tb/dac_dither_gen_test.sv
module dac_dither_gen_test;
  localparam int CW = 14;
  localparam int FW = 16;
  localparam int DIV = 40;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [CW-1:0] wr_int = '0;
  logic [FW-1:0] wr_frac = '0;
  logic [CW-1:0] dac_code;
  logic dac_load;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int m_acc = 0;
  int m_int = 0;
  int m_frac = 0;

  dac_dither_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_int(wr_int),
    .wr_frac(wr_frac), .dac_code(dac_code), .dac_load(dac_load)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp = n_cmp + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_acc = 0; m_int = 0; m_frac = 0;
  endtask

  task automatic do_write(input int iv, input int fv);
    wr_en = 1'b1;
    wr_int = CW'(iv);
    wr_frac = FW'(fv);
    @(negedge clk);
    wr_en = 1'b0;
    m_int = iv; m_frac = fv;
  endtask

  task automatic wait_load();
    @(negedge clk);
    while (!dac_load) @(negedge clk);
  endtask

  // Independent model: returns expected code for the next update.
  function automatic int model_step();
    int s;
    int c;
    s = m_acc + m_frac;
    c = (s >= 65536) ? 1 : 0;
    m_acc = s % 65536;
    if (m_int + c > 16383) return 16383;
    return m_int + c;
  endfunction

  task automatic run_updates(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      int e;
      wait_load();
      e = model_step();
      check(int'(dac_code) == e, req, int'(dac_code), e);
    end
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check(dac_code == '0, "R1 code", int'(dac_code), 0);
    check(dac_load == 1'b0, "R1 load", int'(dac_load), 0);
  endtask

  task automatic t_strobe();
    int gap;
    wait_load();
    @(negedge clk);
    check(dac_load == 1'b0, "R2 width", int'(dac_load), 0);
    gap = 1;
    while (!dac_load) begin
      @(negedge clk);
      gap++;
    end
    check(gap == DIV, "R2 period", gap, DIV);
    m_acc = (m_acc + m_frac) % 65536;
    m_acc = (m_acc + m_frac) % 65536;
  endtask

  task automatic t_zero_frac();
    do_reset();
    do_write(1000, 0);
    run_updates(4, "R3 plain code");
    t_strobe();
  endtask

  task automatic t_pattern();
    do_reset();
    do_write(7000, 16'h4000);
    run_updates(12, "R4 quarter carry");
    do_reset();
    do_write(123, 16'hC001);
    run_updates(12, "R4 mixed carry");
    do_reset();
    do_write(3, 16'hFFFF);
    run_updates(6, "R4 near-full fraction");
  endtask

  task automatic t_saturate();
    do_reset();
    do_write(16383, 16'hFFFF);
    run_updates(6, "R5 full scale");
    do_reset();
    do_write(16382, 16'h8000);
    run_updates(6, "R5 below full scale");
  endtask

  task automatic t_atomic();
    int e;
    do_reset();
    do_write(100, 0);
    wait_load();
    e = model_step();
    check(int'(dac_code) == e, "R6 first pair", int'(dac_code), e);
    repeat (10) @(negedge clk);
    do_write(200, 16'h8000);
    check(int'(dac_code) == 100, "R6 write held off", int'(dac_code), 100);
    check(dac_load == 1'b0, "R6 no extra load", int'(dac_load), 0);
    run_updates(4, "R6 new pair");
  endtask

  task automatic t_count();
    int carries;
    int f;
    int expc;
    f = 23131;
    expc = (1024 * f) / 65536;
    carries = 0;
    do_reset();
    do_write(500, f);
    for (int i = 0; i < 1024; i++) begin
      wait_load();
      if (dac_code == CW'(501)) carries++;
    end
    check(carries == expc, "R7 carry count", carries, expc);
  endtask

  initial begin
    t_reset();
    t_zero_frac();
    t_pattern();
    t_saturate();
    t_atomic();
    t_count();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule